// File: doc/BRIEF.md
# Daisy-Chain Identify Enumerator

This block runs inside each device of a serial chain. It assigns that device its position in the stack during an identify phase. Commands reach it already decoded: a 3-bit command type, a 6-bit address field and a flag that says whether the frame's 4-bit CRC checked. Framing, serialisation and CRC generation happen outside the block. Two static inputs describe the device's place in the chain: a 2-bit communication-select strap, which marks the master when it equals 2'b01, and a top-of-stack indication.

The host starts with the base identify command, which is an identify carrying address 6'h00. The top device answers it with ACK and enters identify mode at once. Every other device stays silent and holds off for a parameterised number of cycles, so that the ACK can travel back to the host, and then enters identify mode. On entry the master takes position 1 and counts as enumerated. Every other device takes position 0. The host then sends identify commands addressed to positions 2, 3 and so on. Each one is claimed by an unaddressed device that is already in identify mode. That device writes the position into both its stack address and its stack size, and returns an identify reply carrying the position. Until a device is enumerated it rejects every command except identify, sleep and wake.

Commands enter through a valid/ready stream and responses leave through a second valid/ready stream. The response stream holds a single slot. While a response waits because `rsp_ready` is low, `cmd_ready` stays low and the response fields do not change. `cmd_ready` is also low while the device is waiting to enter identify mode. A command is accepted in any cycle where `cmd_valid` and `cmd_ready` are both high.

Top module: `enum_chain_ident`

## Requirements
- R1: After reset, `stack_addr` and `stack_size` are 0, `enumerated`, `identify_mode` and `rsp_valid` are low, and `cmd_ready` is high.
- R2: When a top-of-stack device accepts a base identify command (type 0, address 6'h00, CRC good), it queues an ACK response (kind 0), and `identify_mode` is high in the next cycle.
- R3: When a device that is not top of stack accepts a base identify command, it sends no response. It holds `cmd_ready` low while it waits, and `identify_mode` rises exactly WAIT_CYCLES clock edges after the accepting edge.
- R4: On entering identify mode, `stack_addr` becomes 1 and `enumerated` goes high if `comm_sel` equals 2'b01; otherwise `stack_addr` becomes 0.
- R5: A device in identify mode with `stack_addr` 0 that accepts an identify command with address 6'h0N (N from 1 to 15) does the following: it sets `stack_addr` and `stack_size` to N, raises `enumerated`, and returns an identify reply (kind 2) with `rsp_addr` equal to {comm_sel, N}.
- R6: An identify command with a nonzero address produces no response and changes no field in two cases: when the device already holds a nonzero `stack_addr`, and when the device is not in identify mode.
- R7: Before enumeration, an access command (type 3) is answered with NAK (kind 1), while sleep (type 1) and wake (type 2) are answered with ACK. After enumeration, an access command is answered with ACK. ACK and NAK responses carry `rsp_addr` = {comm_sel, stack_addr}.
- R8: A command with `cmd_crc_ok` low, or with a type from 4 to 7, is answered with NAK and does not change the mode or the position.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the response stays valid with unchanged kind and address, and `cmd_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| comm_sel | input | 2 | Communication-select strap; 2'b01 marks the master |
| top_of_stack | input | 1 | High on the device at the top of the chain |
| cmd_valid | input | 1 | Command stream valid |
| cmd_ready | output | 1 | Command stream ready |
| cmd_type | input | 3 | Command type: 0 identify, 1 sleep, 2 wake, 3 access |
| cmd_addr | input | 6 | Address field of the command |
| cmd_crc_ok | input | 1 | The command frame's CRC checked |
| rsp_valid | output | 1 | Response stream valid |
| rsp_ready | input | 1 | Response stream ready |
| rsp_kind | output | 2 | Response kind: 0 ACK, 1 NAK, 2 identify reply |
| rsp_addr | output | 6 | Response address {comm_sel, position} |
| stack_addr | output | 4 | Assigned stack position |
| stack_size | output | 4 | Stack size field |
| enumerated | output | 1 | The device holds a nonzero position |
| identify_mode | output | 1 | The device is in identify mode |

## Verification
The hardest case to reach is the non-top device's hold-off window. It only opens after a base identify arrives while `top_of_stack` is low. During the window nothing on the response port changes, so its length can only be seen through `cmd_ready` falling and `identify_mode` rising. The bench therefore resets the device with the top indication low and the master strap applied, and accepts a base identify. It confirms that `cmd_ready` is low, then counts clock edges until `identify_mode` rises. That count is compared against a WAIT_CYCLES value overridden away from its default. Immediately after entry, the bench sends a claiming identify, which the master must ignore because it already holds position 1.

// File: rtl/enum_chain_pkg.sv
package enum_chain_pkg;

  typedef enum logic [2:0] {
    CMD_IDENT  = 3'd0,
    CMD_SLEEP  = 3'd1,
    CMD_WAKE   = 3'd2,
    CMD_ACCESS = 3'd3
  } cmd_e;

  typedef enum logic [1:0] {
    RSP_ACK     = 2'd0,
    RSP_NAK     = 2'd1,
    RSP_IDREPLY = 2'd2
  } rsp_e;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_WAIT  = 2'd1,
    MODE_IDENT = 2'd2
  } mode_e;

  typedef struct packed {
    logic       rsp_en;
    logic [1:0] kind;
    logic       base_hit;
    logic       claim_hit;
  } decode_t;

endpackage

// File: rtl/enum_cmd_decode.sv
module enum_cmd_decode
  import enum_chain_pkg::*;
#(
  parameter int POS_W  = 4,
  parameter int ADDR_W = 6
) (
  input  logic [2:0]        cmd_type,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              crc_ok,
  input  logic              is_top,
  input  logic              in_ident,
  input  logic              pos_zero,
  input  logic              enumerated,
  output decode_t           dec
);

  logic addr_all_zero;
  logic addr_claimable;

  assign addr_all_zero  = (cmd_addr == '0);
  assign addr_claimable = (cmd_addr[ADDR_W-1:POS_W] == '0) && (cmd_addr[POS_W-1:0] != '0);

  always_comb begin
    dec = '0;
    if (!crc_ok) begin
      dec.rsp_en = 1'b1;
      dec.kind   = RSP_NAK;
    end else begin
      case (cmd_type)
        CMD_IDENT: begin
          if (addr_all_zero) begin
            dec.base_hit = 1'b1;
            dec.rsp_en   = is_top;
            dec.kind     = RSP_ACK;
          end else if (addr_claimable && in_ident && pos_zero) begin
            dec.claim_hit = 1'b1;
            dec.rsp_en    = 1'b1;
            dec.kind      = RSP_IDREPLY;
          end
        end
        CMD_SLEEP, CMD_WAKE: begin
          dec.rsp_en = 1'b1;
          dec.kind   = RSP_ACK;
        end
        CMD_ACCESS: begin
          dec.rsp_en = 1'b1;
          dec.kind   = enumerated ? RSP_ACK : RSP_NAK;
        end
        default: begin
          dec.rsp_en = 1'b1;
          dec.kind   = RSP_NAK;
        end
      endcase
    end
  end

endmodule

// File: rtl/enum_wait_timer.sv
module enum_wait_timer #(
  parameter int WAIT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic expire
);

  localparam int CNT_W = $clog2(WAIT_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  assign busy   = (cnt_q != '0);
  assign expire = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CNT_W'(WAIT_CYCLES);
    end else if (busy) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

endmodule

// File: rtl/enum_rsp_slot.sv
module enum_rsp_slot #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [1:0]        kind_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_kind,
  output logic [ADDR_W-1:0] rsp_addr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_kind  <= '0;
      rsp_addr  <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_kind  <= kind_in;
      rsp_addr  <= addr_in;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/enum_chain_ident.sv
module enum_chain_ident
  import enum_chain_pkg::*;
#(
  parameter int              POS_W       = 4,
  parameter int              SEL_W       = 2,
  parameter logic [SEL_W-1:0] MASTER_SEL = 2'b01,
  parameter int              WAIT_CYCLES = 16,
  localparam int             ADDR_W      = SEL_W + POS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  comm_sel,
  input  logic              top_of_stack,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_type,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_crc_ok,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_kind,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [POS_W-1:0]  stack_addr,
  output logic [POS_W-1:0]  stack_size,
  output logic              enumerated,
  output logic              identify_mode
);

  mode_e             mode_q;
  logic [POS_W-1:0]  pos_q;
  logic [POS_W-1:0]  size_q;
  logic              enum_q;
  decode_t           dec;
  logic              accept;
  logic              wait_busy;
  logic              wait_expire;
  logic              is_master;
  logic              enter_ident;
  logic [ADDR_W-1:0] rsp_addr_next;

  assign is_master     = (comm_sel == MASTER_SEL);
  assign cmd_ready     = !rsp_valid && !wait_busy;
  assign accept        = cmd_valid && cmd_ready;
  assign enter_ident   = (accept && dec.base_hit && top_of_stack) || wait_expire;
  assign identify_mode = (mode_q == MODE_IDENT);
  assign stack_addr    = pos_q;
  assign stack_size    = size_q;
  assign enumerated    = enum_q;
  assign rsp_addr_next = dec.claim_hit ? {comm_sel, cmd_addr[POS_W-1:0]} : {comm_sel, pos_q};

  enum_cmd_decode #(.POS_W(POS_W), .ADDR_W(ADDR_W)) u_dec (
    .cmd_type   (cmd_type),
    .cmd_addr   (cmd_addr),
    .crc_ok     (cmd_crc_ok),
    .is_top     (top_of_stack),
    .in_ident   (identify_mode),
    .pos_zero   (pos_q == '0),
    .enumerated (enum_q),
    .dec        (dec)
  );

  enum_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept && dec.base_hit && !top_of_stack),
    .busy   (wait_busy),
    .expire (wait_expire)
  );

  enum_rsp_slot #(.ADDR_W(ADDR_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept && dec.rsp_en),
    .kind_in   (dec.kind),
    .addr_in   (rsp_addr_next),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_kind  (rsp_kind),
    .rsp_addr  (rsp_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_IDLE;
      pos_q  <= '0;
      size_q <= '0;
      enum_q <= 1'b0;
    end else if (enter_ident) begin
      mode_q <= MODE_IDENT;
      pos_q  <= is_master ? POS_W'(1) : POS_W'(0);
      enum_q <= is_master;
    end else if (accept && dec.base_hit) begin
      mode_q <= MODE_WAIT;
      enum_q <= 1'b0;
    end else if (accept && dec.claim_hit) begin
      pos_q  <= cmd_addr[POS_W-1:0];
      size_q <= cmd_addr[POS_W-1:0];
      enum_q <= 1'b1;
    end
  end

endmodule

// File: rtl/enum_chain_ident_chk.sv
module enum_chain_ident_chk #(
  parameter int               POS_W      = 4,
  parameter int               SEL_W      = 2,
  parameter logic [SEL_W-1:0] MASTER_SEL = 2'b01
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [SEL_W-1:0]       comm_sel,
  input logic                   cmd_valid,
  input logic                   cmd_ready,
  input logic [2:0]             cmd_type,
  input logic [SEL_W+POS_W-1:0] cmd_addr,
  input logic                   cmd_crc_ok,
  input logic                   rsp_valid,
  input logic                   rsp_ready,
  input logic [1:0]             rsp_kind,
  input logic [SEL_W+POS_W-1:0] rsp_addr,
  input logic [POS_W-1:0]       stack_addr,
  input logic                   enumerated,
  input logic                   identify_mode,
  input logic                   wait_busy
);

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_kind) && $stable(rsp_addr));

  a_r9_no_accept_pending: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);

  a_r3_wait_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    wait_busy |-> !cmd_ready && !identify_mode);

  a_r4_entry_default: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(identify_mode) |-> stack_addr == ((comm_sel == MASTER_SEL) ? POS_W'(1) : POS_W'(0)));

  a_r6_position_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    identify_mode && stack_addr != '0 &&
    !(cmd_valid && cmd_ready && cmd_crc_ok && cmd_type == 3'd0 && cmd_addr == '0)
    |=> $stable(stack_addr));

  a_r8_nak_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && (!cmd_crc_ok || cmd_type > 3'd3) |=> rsp_valid && rsp_kind == 2'd1);

  a_r5_reply_matches: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind == 2'd2 |-> enumerated && rsp_addr[POS_W-1:0] == stack_addr);

endmodule

bind enum_chain_ident enum_chain_ident_chk #(
  .POS_W(POS_W), .SEL_W(SEL_W), .MASTER_SEL(MASTER_SEL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .comm_sel(comm_sel), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_type(cmd_type), .cmd_addr(cmd_addr),
  .cmd_crc_ok(cmd_crc_ok), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_kind(rsp_kind), .rsp_addr(rsp_addr), .stack_addr(stack_addr),
  .enumerated(enumerated), .identify_mode(identify_mode), .wait_busy(wait_busy)
);

// File: tb/sim_enum_chain_ident.sv
`timescale 1ns/1ps
module sim_enum_chain_ident;

  localparam int WAITC = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] comm_sel = 2'b00;
  logic       top_of_stack = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_type = 3'd0;
  logic [5:0] cmd_addr = 6'd0;
  logic       cmd_crc_ok = 1'b1;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [1:0] rsp_kind;
  logic [5:0] rsp_addr;
  logic [3:0] stack_addr;
  logic [3:0] stack_size;
  logic       enumerated;
  logic       identify_mode;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  enum_chain_ident #(.WAIT_CYCLES(WAITC)) u0 (
    .clk(clk), .rst_n(rst_n), .comm_sel(comm_sel), .top_of_stack(top_of_stack),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_type(cmd_type),
    .cmd_addr(cmd_addr), .cmd_crc_ok(cmd_crc_ok), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_addr(rsp_addr),
    .stack_addr(stack_addr), .stack_size(stack_size), .enumerated(enumerated),
    .identify_mode(identify_mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] sel, input logic top);
    @(negedge clk);
    rst_n = 1'b0;
    comm_sel = sel;
    top_of_stack = top;
    cmd_valid = 1'b0;
    rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Presents one command, waits for its acceptance edge and returns at the
  // falling edge right after it.
  task automatic send(input logic [2:0] t, input logic [5:0] a, input logic crc);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_type = t;
    cmd_addr = a;
    cmd_crc_ok = crc;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_crc_ok = 1'b1;
  endtask

  task automatic t_reset;
    do_reset(2'b00, 1'b1);
    chk("R1 stack_addr", stack_addr, 0);
    chk("R1 stack_size", stack_size, 0);
    chk("R1 enumerated", enumerated, 0);
    chk("R1 identify_mode", identify_mode, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 cmd_ready", cmd_ready, 1);
  endtask

  task automatic t_top_base_and_claim;
    do_reset(2'b00, 1'b1);
    send(3'd0, 6'h00, 1'b1);
    chk("R2 ack valid", rsp_valid, 1);
    chk("R2 ack kind", rsp_kind, 0);
    chk("R2 ack addr", rsp_addr, 0);
    chk("R2 identify_mode", identify_mode, 1);
    chk("R4 non-master pos", stack_addr, 0);
    chk("R4 non-master enumerated", enumerated, 0);
    send(3'd0, 6'h02, 1'b1);
    chk("R5 reply valid", rsp_valid, 1);
    chk("R5 reply kind", rsp_kind, 2);
    chk("R5 reply addr", rsp_addr, 6'h02);
    chk("R5 stack_addr", stack_addr, 2);
    chk("R5 stack_size", stack_size, 2);
    chk("R5 enumerated", enumerated, 1);
    send(3'd0, 6'h05, 1'b1);
    chk("R6 assigned no rsp", rsp_valid, 0);
    chk("R6 assigned addr kept", stack_addr, 2);
    chk("R6 assigned size kept", stack_size, 2);
    send(3'd3, 6'h00, 1'b1);
    chk("R7 access after enum kind", rsp_kind, 0);
    chk("R7 access rsp addr", rsp_addr, 6'h02);
    send(3'd0, 6'h00, 1'b0);
    chk("R8 bad crc kind", rsp_kind, 1);
    chk("R8 bad crc valid", rsp_valid, 1);
    chk("R8 bad crc mode kept", identify_mode, 1);
    chk("R8 bad crc addr kept", stack_addr, 2);
    send(3'd5, 6'h00, 1'b1);
    chk("R8 bad type kind", rsp_kind, 1);
    chk("R8 bad type addr kept", stack_addr, 2);
  endtask

  task automatic t_claim_high_position;
    do_reset(2'b10, 1'b1);
    send(3'd0, 6'h00, 1'b1);
    send(3'd0, 6'h0F, 1'b1);
    chk("R5 pos15 kind", rsp_kind, 2);
    chk("R5 pos15 addr", rsp_addr, 6'h2F);
    chk("R5 pos15 stack_addr", stack_addr, 15);
  endtask

  task automatic t_nontop_master;
    int edges;
    do_reset(2'b01, 1'b0);
    send(3'd3, 6'h00, 1'b1);
    chk("R7 access before enum kind", rsp_kind, 1);
    send(3'd1, 6'h00, 1'b1);
    chk("R7 sleep kind", rsp_kind, 0);
    send(3'd2, 6'h00, 1'b1);
    chk("R7 wake kind", rsp_kind, 0);
    chk("R7 wake addr", rsp_addr, 6'h10);
    send(3'd0, 6'h03, 1'b1);
    chk("R6 idle claim no rsp", rsp_valid, 0);
    chk("R6 idle claim addr", stack_addr, 0);
    send(3'd0, 6'h00, 1'b1);
    chk("R3 no response", rsp_valid, 0);
    chk("R3 ready low", cmd_ready, 0);
    edges = 0;
    while (!identify_mode && edges < 100) begin
      @(posedge clk);
      @(negedge clk);
      edges++;
      if (edges < WAITC) chk("R3 ready held low", cmd_ready, 0);
    end
    chk("R3 wait edges", edges, WAITC);
    chk("R4 master pos", stack_addr, 1);
    chk("R4 master enumerated", enumerated, 1);
    send(3'd0, 6'h03, 1'b1);
    chk("R6 master claim no rsp", rsp_valid, 0);
    chk("R6 master addr kept", stack_addr, 1);
  endtask

  task automatic t_backpressure;
    do_reset(2'b00, 1'b0);
    @(negedge clk);
    rsp_ready = 1'b0;
    send(3'd1, 6'h00, 1'b1);
    for (int i = 0; i < 3; i++) begin
      chk("R9 held valid", rsp_valid, 1);
      chk("R9 held kind", rsp_kind, 0);
      chk("R9 cmd blocked", cmd_ready, 0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9 released", rsp_valid, 0);
    chk("R9 ready back", cmd_ready, 1);
  endtask

  initial begin
    t_reset();
    t_top_base_and_claim();
    t_claim_high_position();
    t_nontop_master();
    t_backpressure();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule